// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block sits beside an 8-bit processor core and is consulted each time the core reaches an instruction boundary. On the boundary strobe it looks at the pending reset, delayed non-maskable, non-maskable and maskable interrupt conditions, chooses at most one, and then runs that entry on a byte-wide memory port. Entries push the return address and status onto the stack page and fetch a 16-bit handler address. The core's state stays outside the block: the block takes the core's program counter, status and stack pointer as inputs and hands back load strobes with the new values.

The block holds the request state itself. Requests arrive as one-cycle pulses: reset, non-maskable, delayed non-maskable and a one-shot maskable request. A small set of level sources can each be set and cleared on its own, and the core can report that it has jammed. The maskable path is gated by the interrupt-disable flag as it stood at the start of the previous instruction, which the core supplies, so a change to that flag takes effect one instruction late.

Top module: `intr_entry`

## Requirements
- R1: On an accepted boundary the block handles at most one condition, in the priority order reset, delayed non-maskable, non-maskable, maskable. When the action completes, `done_o` pulses for one cycle and `kind_o` reports it with the encoding 1 reset, 2 promotion, 3 non-maskable, 4 maskable. A boundary with nothing to handle gives no `done_o`, no bus access and no load.
- R2: Leaving reset, a reset request is pending. A reset entry reads the handler address low byte from 0xFFFC and high byte from 0xFFFD. It loads the program counter with that address and the status with exactly 0x04. It makes no stack writes and no stack pointer load, keeps `busy_o` high for 3 cycles and reports `cycles_o` = 0.
- R3: A delayed non-maskable request is never serviced on its own boundary. It is cleared and becomes an ordinary pending non-maskable request. That boundary reports kind 2 with one busy cycle, `cycles_o` = 0 and no bus access, and the non-maskable entry runs at the next boundary.
- R4: A non-maskable or maskable entry writes three bytes in this order: the program counter high byte to 0x0100+S, the low byte to 0x0100+((S-1) mod 256) and the status to 0x0100+((S-2) mod 256), where S is `sp_i` at the boundary. It then loads the stack pointer with (S-3) mod 256.
- R5: The pushed status is `p_i` with bit 4 cleared and bit 5 set. The status loaded at the end of the entry is `p_i` with bit 2 (interrupt disable) set.
- R6: A non-maskable entry reads its handler address from 0xFFFA (low) and 0xFFFB (high) and clears the pending non-maskable request. A maskable entry reads from 0xFFFE (low) and 0xFFFF (high).
- R7: A non-maskable or maskable entry keeps `busy_o` high for exactly 7 cycles after the boundary and reports `cycles_o` = 7 with `done_o`.
- R8: A maskable entry is taken only when `i_prev_i` is 0 at the boundary; with `i_prev_i` at 1 the maskable line is ignored.
- R9: Each level source bit is set by its bit of `irq_set_i` and cleared by its bit of `irq_clr_i`; set wins when both are raised. `irq_line_o` is 1 while any source bit or the one-shot bit is set. A maskable entry leaves the source bits unchanged, so a source still set is taken again at a later boundary.
- R10: The one-shot maskable bit is cleared at every accepted boundary, whether or not an entry is taken.
- R11: `jam_i` sets a jammed state shown on `jammed_o`. While jammed, non-maskable and maskable entries are skipped, and a pending non-maskable request stays pending. Only a reset entry clears the jammed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction boundary strobe, honoured while not busy |
| reset_req_i | input | 1 | Reset request pulse |
| nmi_req_i | input | 1 | Non-maskable request pulse |
| nmi_late_req_i | input | 1 | Delayed non-maskable request pulse |
| irq_set_i | input | NSRC | Per-source set strobes for level maskable sources |
| irq_clr_i | input | NSRC | Per-source clear strobes |
| irq_shot_i | input | 1 | One-shot maskable request pulse |
| jam_i | input | 1 | Core reports it has jammed |
| i_prev_i | input | 1 | Interrupt-disable flag at the start of the previous instruction |
| pc_i | input | 16 | Core program counter |
| p_i | input | 8 | Core status |
| sp_i | input | 8 | Core stack pointer |
| bus_rdata_i | input | 8 | Read data for the address driven this cycle |
| bus_addr_o | output | 16 | Memory address |
| bus_wdata_o | output | 8 | Memory write data |
| bus_we_o | output | 1 | Memory write strobe |
| bus_re_o | output | 1 | Memory read strobe |
| pc_o | output | 16 | New program counter |
| pc_load_o | output | 1 | Program counter load strobe |
| p_o | output | 8 | New status |
| p_load_o | output | 1 | Status load strobe |
| sp_o | output | 8 | New stack pointer |
| sp_load_o | output | 1 | Stack pointer load strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Action complete |
| kind_o | output | 3 | Action reported with done_o |
| cycles_o | output | 4 | Cycles charged by the action |
| jammed_o | output | 1 | Jammed state |
| irq_line_o | output | 1 | Combined maskable request line |

## Verification
The bench sweeps all sixteen combinations of pending reset, delayed non-maskable, non-maskable and maskable conditions, which separates each step of the priority order from the one below it. Each level source is raised alone to show that every bit drives the line and survives entry. Entries use a stack pointer in mid-page and one that wraps below 0x0100, and status values with bit 4 set and bit 5 clear, which shows the push order, the page wrap and the flag rewrite apart. Gating, one-shot and jam cases each pair an ignored boundary with a following one, so a suppressed entry is told apart from a lost request.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;

    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_RESET   = 3'd1,
        K_PROMOTE = 3'd2,
        K_NMI     = 3'd3,
        K_IRQ     = 3'd4
    } entry_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_PUSH_PCH,
        ST_PUSH_PCL,
        ST_PUSH_PSR,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_LOAD,
        ST_PROMOTE
    } seq_state_e;

    typedef struct packed {
        logic [15:0] pc;
        logic [7:0]  p;
        logic [7:0]  sp;
    } cpu_snap_t;

    localparam logic [15:0] VEC_NMI   = 16'hFFFA;
    localparam logic [15:0] VEC_RESET = 16'hFFFC;
    localparam logic [15:0] VEC_IRQ   = 16'hFFFE;
    localparam logic [7:0]  STACK_PAGE = 8'h01;
    localparam int FLAG_I = 2;
    localparam int FLAG_B = 4;
    localparam int FLAG_U = 5;
    localparam int CYC_W = 4;
    localparam int ENTRY_CYCLES = 7;
    localparam int RESET_BUSY = 3;
    localparam logic [7:0] RESET_STATUS = 8'h04;

    function automatic logic [7:0] push_status(input logic [7:0] p);
        logic [7:0] r;
        r = p;
        r[FLAG_B] = 1'b0;
        r[FLAG_U] = 1'b1;
        return r;
    endfunction

    function automatic logic [15:0] stack_addr(input logic [7:0] sp, input logic [7:0] back);
        logic [7:0] off;
        off = sp - back;
        return {STACK_PAGE, off};
    endfunction

    function automatic logic [15:0] vector_base(input entry_kind_e k);
        case (k)
            K_RESET: return VEC_RESET;
            K_NMI:   return VEC_NMI;
            default: return VEC_IRQ;
        endcase
    endfunction

    function automatic logic is_entry(input entry_kind_e k);
        return (k == K_NMI) || (k == K_IRQ);
    endfunction

endpackage

// File: rtl/intr_entry_req.sv
module intr_entry_req
    import intr_entry_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reset_req_i,
    input  logic            nmi_req_i,
    input  logic            nmi_late_req_i,
    input  logic [NSRC-1:0] irq_set_i,
    input  logic [NSRC-1:0] irq_clr_i,
    input  logic            irq_shot_i,
    input  logic            jam_i,
    input  logic            accept_i,
    input  entry_kind_e     take_kind_i,
    output logic            rst_pend_o,
    output logic            late_pend_o,
    output logic            nmi_pend_o,
    output logic            irq_line_o,
    output logic            jammed_o
);

    logic            rst_q, late_q, nmi_q, shot_q, jam_q;
    logic [NSRC-1:0] src_q;

    logic take_rst, take_promote, take_nmi;
    assign take_rst     = accept_i && (take_kind_i == K_RESET);
    assign take_promote = accept_i && (take_kind_i == K_PROMOTE);
    assign take_nmi     = accept_i && (take_kind_i == K_NMI);

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_q  <= 1'b1;
            late_q <= 1'b0;
            nmi_q  <= 1'b0;
            shot_q <= 1'b0;
            jam_q  <= 1'b0;
        end else begin
            if (reset_req_i)   rst_q <= 1'b1;
            else if (take_rst) rst_q <= 1'b0;

            if (nmi_late_req_i)    late_q <= 1'b1;
            else if (take_promote) late_q <= 1'b0;

            if (nmi_req_i || take_promote) nmi_q <= 1'b1;
            else if (take_nmi)             nmi_q <= 1'b0;

            if (irq_shot_i)    shot_q <= 1'b1;
            else if (accept_i) shot_q <= 1'b0;

            if (jam_i)         jam_q <= 1'b1;
            else if (take_rst) jam_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)               src_q[g] <= 1'b0;
            else if (irq_set_i[g]) src_q[g] <= 1'b1;
            else if (irq_clr_i[g]) src_q[g] <= 1'b0;
        end
    end

    assign rst_pend_o  = rst_q;
    assign late_pend_o = late_q;
    assign nmi_pend_o  = nmi_q;
    assign irq_line_o  = (|src_q) || shot_q;
    assign jammed_o    = jam_q;

    a_r3_promote_to_nmi: assert property (@(posedge clk) disable iff (rst)
        take_promote |=> nmi_q);

    a_r6_nmi_cleared: assert property (@(posedge clk) disable iff (rst)
        (take_nmi && !nmi_req_i) |=> !nmi_q);

    a_r11_reset_unjams: assert property (@(posedge clk) disable iff (rst)
        (take_rst && !jam_i) |=> !jam_q);

    a_r11_no_entry_jammed: assert property (@(posedge clk) disable iff (rst)
        (accept_i && is_entry(take_kind_i)) |-> !jam_q);

    a_r10_shot_cleared: assert property (@(posedge clk) disable iff (rst)
        (accept_i && !irq_shot_i) |=> !shot_q);

    a_r9_sources_kept: assert property (@(posedge clk) disable iff (rst)
        (accept_i && (take_kind_i == K_IRQ) && !(|irq_clr_i))
            |=> ((src_q & $past(src_q)) == $past(src_q)));

endmodule

// File: rtl/intr_entry_arb.sv
module intr_entry_arb
    import intr_entry_pkg::*;
(
    input  logic        rst_pend_i,
    input  logic        late_pend_i,
    input  logic        nmi_pend_i,
    input  logic        irq_line_i,
    input  logic        i_prev_i,
    input  logic        jammed_i,
    output entry_kind_e kind_o
);

    always_comb begin
        if (rst_pend_i)
            kind_o = K_RESET;
        else if (late_pend_i)
            kind_o = K_PROMOTE;
        else if (nmi_pend_i)
            kind_o = jammed_i ? K_NONE : K_NMI;
        else if (irq_line_i && !i_prev_i && !jammed_i)
            kind_o = K_IRQ;
        else
            kind_o = K_NONE;
    end

endmodule

// File: rtl/intr_entry_fsm.sv
module intr_entry_fsm
    import intr_entry_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             boundary_i,
    input  entry_kind_e      kind_i,
    input  logic [15:0]      pc_i,
    input  logic [7:0]       p_i,
    input  logic [7:0]       sp_i,
    input  logic [7:0]       bus_rdata_i,
    output logic             accept_o,
    output logic [15:0]      bus_addr_o,
    output logic [7:0]       bus_wdata_o,
    output logic             bus_we_o,
    output logic             bus_re_o,
    output logic [15:0]      pc_o,
    output logic             pc_load_o,
    output logic [7:0]       p_o,
    output logic             p_load_o,
    output logic [7:0]       sp_o,
    output logic             sp_load_o,
    output logic             busy_o,
    output logic             done_o,
    output entry_kind_e      kind_o,
    output logic [CYC_W-1:0] cycles_o
);

    seq_state_e  state_q, state_d;
    entry_kind_e kind_q;
    cpu_snap_t   snap_q;
    logic [7:0]  vec_lo_q, vec_hi_q;

    assign accept_o = boundary_i && (state_q == ST_IDLE) && !rst;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (accept_o) begin
                    case (kind_i)
                        K_RESET:       state_d = ST_VEC_LO;
                        K_PROMOTE:     state_d = ST_PROMOTE;
                        K_NMI, K_IRQ:  state_d = ST_SETTLE;
                        default:       state_d = ST_IDLE;
                    endcase
                end
            end
            ST_SETTLE:   state_d = ST_PUSH_PCH;
            ST_PUSH_PCH: state_d = ST_PUSH_PCL;
            ST_PUSH_PCL: state_d = ST_PUSH_PSR;
            ST_PUSH_PSR: state_d = ST_VEC_LO;
            ST_VEC_LO:   state_d = ST_VEC_HI;
            ST_VEC_HI:   state_d = ST_LOAD;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            kind_q   <= K_NONE;
            snap_q   <= '0;
            vec_lo_q <= 8'h00;
            vec_hi_q <= 8'h00;
        end else begin
            state_q <= state_d;
            if (accept_o) begin
                kind_q <= kind_i;
                snap_q <= '{pc: pc_i, p: p_i, sp: sp_i};
            end
            if (state_q == ST_VEC_LO) vec_lo_q <= bus_rdata_i;
            if (state_q == ST_VEC_HI) vec_hi_q <= bus_rdata_i;
        end
    end

    always_comb begin
        bus_addr_o  = 16'h0000;
        bus_wdata_o = 8'h00;
        bus_we_o    = 1'b0;
        bus_re_o    = 1'b0;
        pc_o        = 16'h0000;
        pc_load_o   = 1'b0;
        p_o         = 8'h00;
        p_load_o    = 1'b0;
        sp_o        = 8'h00;
        sp_load_o   = 1'b0;
        done_o      = 1'b0;
        kind_o      = K_NONE;
        cycles_o    = '0;
        case (state_q)
            ST_PUSH_PCH: begin
                bus_we_o    = 1'b1;
                bus_addr_o  = stack_addr(snap_q.sp, 8'd0);
                bus_wdata_o = snap_q.pc[15:8];
            end
            ST_PUSH_PCL: begin
                bus_we_o    = 1'b1;
                bus_addr_o  = stack_addr(snap_q.sp, 8'd1);
                bus_wdata_o = snap_q.pc[7:0];
            end
            ST_PUSH_PSR: begin
                bus_we_o    = 1'b1;
                bus_addr_o  = stack_addr(snap_q.sp, 8'd2);
                bus_wdata_o = push_status(snap_q.p);
            end
            ST_VEC_LO: begin
                bus_re_o   = 1'b1;
                bus_addr_o = vector_base(kind_q);
            end
            ST_VEC_HI: begin
                bus_re_o   = 1'b1;
                bus_addr_o = vector_base(kind_q) + 16'd1;
            end
            ST_LOAD: begin
                pc_o      = {vec_hi_q, vec_lo_q};
                pc_load_o = 1'b1;
                p_load_o  = 1'b1;
                done_o    = 1'b1;
                kind_o    = kind_q;
                if (kind_q == K_RESET) begin
                    p_o = RESET_STATUS;
                end else begin
                    p_o         = snap_q.p;
                    p_o[FLAG_I] = 1'b1;
                    sp_o        = snap_q.sp - 8'd3;
                    sp_load_o   = 1'b1;
                    cycles_o    = CYC_W'(ENTRY_CYCLES);
                end
            end
            ST_PROMOTE: begin
                done_o = 1'b1;
                kind_o = K_PROMOTE;
            end
            default: ;
        endcase
    end

    assign busy_o = (state_q != ST_IDLE);

    logic [CYC_W-1:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)         run_q <= '0;
        else if (busy_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    a_r7_entry_length: assert property (@(posedge clk) disable iff (rst)
        (done_o && is_entry(kind_o)) |-> (run_q == CYC_W'(ENTRY_CYCLES - 1)));

    a_r2_reset_length: assert property (@(posedge clk) disable iff (rst)
        (done_o && (kind_o == K_RESET)) |-> (run_q == CYC_W'(RESET_BUSY - 1)));

    a_r4_stack_page: assert property (@(posedge clk) disable iff (rst)
        bus_we_o |-> (bus_addr_o[15:8] == STACK_PAGE));

    a_r5_disable_set: assert property (@(posedge clk) disable iff (rst)
        p_load_o |-> p_o[FLAG_I]);

    a_r6_vector_before_load: assert property (@(posedge clk) disable iff (rst)
        pc_load_o |-> $past(bus_re_o));

    a_r1_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/intr_entry.sv
module intr_entry
    import intr_entry_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            boundary_i,
    input  logic            reset_req_i,
    input  logic            nmi_req_i,
    input  logic            nmi_late_req_i,
    input  logic [NSRC-1:0] irq_set_i,
    input  logic [NSRC-1:0] irq_clr_i,
    input  logic            irq_shot_i,
    input  logic            jam_i,
    input  logic            i_prev_i,
    input  logic [15:0]     pc_i,
    input  logic [7:0]      p_i,
    input  logic [7:0]      sp_i,
    input  logic [7:0]      bus_rdata_i,
    output logic [15:0]     bus_addr_o,
    output logic [7:0]      bus_wdata_o,
    output logic            bus_we_o,
    output logic            bus_re_o,
    output logic [15:0]     pc_o,
    output logic            pc_load_o,
    output logic [7:0]      p_o,
    output logic            p_load_o,
    output logic [7:0]      sp_o,
    output logic            sp_load_o,
    output logic            busy_o,
    output logic            done_o,
    output logic [2:0]      kind_o,
    output logic [3:0]      cycles_o,
    output logic            jammed_o,
    output logic            irq_line_o
);

    logic        rst_pend, late_pend, nmi_pend, accept;
    entry_kind_e pick_kind, done_kind;

    intr_entry_req #(.NSRC(NSRC)) u_req (
        .clk            (clk),
        .rst            (rst),
        .reset_req_i    (reset_req_i),
        .nmi_req_i      (nmi_req_i),
        .nmi_late_req_i (nmi_late_req_i),
        .irq_set_i      (irq_set_i),
        .irq_clr_i      (irq_clr_i),
        .irq_shot_i     (irq_shot_i),
        .jam_i          (jam_i),
        .accept_i       (accept),
        .take_kind_i    (pick_kind),
        .rst_pend_o     (rst_pend),
        .late_pend_o    (late_pend),
        .nmi_pend_o     (nmi_pend),
        .irq_line_o     (irq_line_o),
        .jammed_o       (jammed_o)
    );

    intr_entry_arb u_arb (
        .rst_pend_i  (rst_pend),
        .late_pend_i (late_pend),
        .nmi_pend_i  (nmi_pend),
        .irq_line_i  (irq_line_o),
        .i_prev_i    (i_prev_i),
        .jammed_i    (jammed_o),
        .kind_o      (pick_kind)
    );

    intr_entry_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .boundary_i  (boundary_i),
        .kind_i      (pick_kind),
        .pc_i        (pc_i),
        .p_i         (p_i),
        .sp_i        (sp_i),
        .bus_rdata_i (bus_rdata_i),
        .accept_o    (accept),
        .bus_addr_o  (bus_addr_o),
        .bus_wdata_o (bus_wdata_o),
        .bus_we_o    (bus_we_o),
        .bus_re_o    (bus_re_o),
        .pc_o        (pc_o),
        .pc_load_o   (pc_load_o),
        .p_o         (p_o),
        .p_load_o    (p_load_o),
        .sp_o        (sp_o),
        .sp_load_o   (sp_load_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .kind_o      (done_kind),
        .cycles_o    (cycles_o)
    );

    assign kind_o = done_kind;

    a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
        (accept && (pick_kind == K_IRQ)) |-> (!i_prev_i && irq_line_o));

endmodule

// File: tb/intr_entry_tb.sv
module intr_entry_tb;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic boundary = 1'b0, reset_req = 1'b0, nmi_req = 1'b0, late_req = 1'b0;
    logic [N-1:0] irq_set = '0, irq_clr = '0;
    logic shot = 1'b0, jam = 1'b0, i_prev = 1'b0;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  p_in = 8'h00, sp_in = 8'hFF;
    logic [7:0]  rdata;
    logic [15:0] bus_addr, pc_o;
    logic [7:0]  bus_wdata, p_o, sp_o;
    logic bus_we, bus_re, pc_load, p_load, sp_load, busy, done, jammed, irq_line;
    logic [2:0] kind;
    logic [3:0] cycles;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] rom(input logic [15:0] a);
        case (a)
            16'hFFFA: return 8'h11;
            16'hFFFB: return 8'h90;
            16'hFFFC: return 8'h34;
            16'hFFFD: return 8'h12;
            16'hFFFE: return 8'h78;
            16'hFFFF: return 8'hC6;
            default:  return 8'hEE;
        endcase
    endfunction
    assign rdata = rom(bus_addr);

    intr_entry #(.NSRC(N)) u_dut (
        .clk(clk), .rst(rst), .boundary_i(boundary), .reset_req_i(reset_req),
        .nmi_req_i(nmi_req), .nmi_late_req_i(late_req), .irq_set_i(irq_set),
        .irq_clr_i(irq_clr), .irq_shot_i(shot), .jam_i(jam), .i_prev_i(i_prev),
        .pc_i(pc_in), .p_i(p_in), .sp_i(sp_in), .bus_rdata_i(rdata),
        .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_we_o(bus_we),
        .bus_re_o(bus_re), .pc_o(pc_o), .pc_load_o(pc_load), .p_o(p_o),
        .p_load_o(p_load), .sp_o(sp_o), .sp_load_o(sp_load), .busy_o(busy),
        .done_o(done), .kind_o(kind), .cycles_o(cycles), .jammed_o(jammed),
        .irq_line_o(irq_line)
    );

    int obs_kind, obs_busy, obs_wcnt, obs_done, obs_pcl, obs_spl;
    logic [15:0] obs_waddr [0:7];
    logic [7:0]  obs_wdata [0:7];
    logic [15:0] obs_pc;
    logic [7:0]  obs_p, obs_sp;
    logic [3:0]  obs_cyc;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic pulse(input bit r, input bit l, input bit n, input bit s,
                         input logic [N-1:0] st, input logic [N-1:0] cl, input bit j);
        @(negedge clk);
        reset_req = r; late_req = l; nmi_req = n; shot = s;
        irq_set = st; irq_clr = cl; jam = j;
        @(negedge clk);
        reset_req = 0; late_req = 0; nmi_req = 0; shot = 0;
        irq_set = '0; irq_clr = '0; jam = 0;
    endtask

    task automatic run_bnd();
        obs_kind = 0; obs_busy = 0; obs_wcnt = 0; obs_done = 0;
        obs_pcl = 0; obs_spl = 0; obs_pc = '0; obs_p = '0; obs_sp = '0; obs_cyc = '0;
        @(negedge clk);
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (busy) obs_busy++;
            if (bus_we && obs_wcnt < 8) begin
                obs_waddr[obs_wcnt] = bus_addr;
                obs_wdata[obs_wcnt] = bus_wdata;
                obs_wcnt++;
            end
            if (done) begin
                obs_done++;
                obs_kind = int'(kind);
                obs_cyc = cycles;
            end
            if (pc_load) begin obs_pcl++; obs_pc = pc_o; end
            if (p_load) obs_p = p_o;
            if (sp_load) begin obs_spl++; obs_sp = sp_o; end
            @(negedge clk);
        end
    endtask

    task automatic expect_entry(input string tag, input int k, input logic [15:0] pc,
                                input logic [7:0] p, input logic [7:0] sp,
                                input logic [15:0] vec);
        logic [7:0] s1, s2, s3, pushed, loaded;
        s1 = sp - 8'd1; s2 = sp - 8'd2; s3 = sp - 8'd3;
        pushed = (p & 8'hEF) | 8'h20;
        loaded = p | 8'h04;
        chk({tag, " R1 kind"}, obs_kind, k);
        chk({tag, " R7 busy cycles"}, obs_busy, 7);
        chk({tag, " R7 cycles_o"}, obs_cyc, 4'd7);
        chk({tag, " R4 write count"}, obs_wcnt, 3);
        chk({tag, " R4 pch addr"}, obs_waddr[0], {8'h01, sp});
        chk({tag, " R4 pch data"}, obs_wdata[0], pc[15:8]);
        chk({tag, " R4 pcl addr"}, obs_waddr[1], {8'h01, s1});
        chk({tag, " R4 pcl data"}, obs_wdata[1], pc[7:0]);
        chk({tag, " R4 psr addr"}, obs_waddr[2], {8'h01, s2});
        chk({tag, " R5 pushed status"}, obs_wdata[2], pushed);
        chk({tag, " R4 sp load"}, obs_sp, s3);
        chk({tag, " R5 loaded status"}, obs_p, loaded);
        chk({tag, " R6 vector"}, obs_pc, vec);
    endtask

    task automatic expect_reset(input string tag);
        chk({tag, " R2 kind"}, obs_kind, 1);
        chk({tag, " R2 pc"}, obs_pc, 16'h1234);
        chk({tag, " R2 status"}, obs_p, 8'h04);
        chk({tag, " R2 no pushes"}, obs_wcnt, 0);
        chk({tag, " R2 no sp load"}, obs_spl, 0);
        chk({tag, " R2 busy"}, obs_busy, 3);
        chk({tag, " R2 cycles_o"}, obs_cyc, 4'd0);
    endtask

    task automatic expect_none(input string tag);
        chk({tag, " R1 no done"}, obs_done, 0);
        chk({tag, " R1 no bus write"}, obs_wcnt, 0);
        chk({tag, " R1 no pc load"}, obs_pcl, 0);
        chk({tag, " R1 not busy"}, obs_busy, 0);
    endtask

    task automatic expect_promote(input string tag);
        chk({tag, " R3 kind"}, obs_kind, 2);
        chk({tag, " R3 busy"}, obs_busy, 1);
        chk({tag, " R3 no bus write"}, obs_wcnt, 0);
        chk({tag, " R3 no pc load"}, obs_pcl, 0);
        chk({tag, " R3 cycles_o"}, obs_cyc, 4'd0);
    endtask

    task automatic drain();
        i_prev = 1'b1;
        for (int i = 0; i < 5; i++) begin
            run_bnd();
            if (obs_done == 0) break;
        end
        i_prev = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset busy", busy, 1'b0);
        chk("R1 reset done", done, 1'b0);
        chk("R11 reset jammed", jammed, 1'b0);
        chk("R9 reset irq line", irq_line, 1'b0);
        chk("R4 reset we", bus_we, 1'b0);

        run_bnd(); expect_reset("first");
        run_bnd(); expect_none("idle");

        pc_in = 16'hABCD; p_in = 8'hD3; sp_in = 8'hFD;
        pulse(0, 0, 1, 0, '0, '0, 0);
        run_bnd(); expect_entry("nmi", 3, 16'hABCD, 8'hD3, 8'hFD, 16'h9011);
        run_bnd(); expect_none("R6 nmi cleared");

        pulse(0, 0, 0, 0, 4'b0010, '0, 0);
        chk("R9 line from source", irq_line, 1'b1);
        i_prev = 1'b1;
        run_bnd(); expect_none("R8 gated");
        i_prev = 1'b0;
        pc_in = 16'h0200; p_in = 8'h20; sp_in = 8'h01;
        run_bnd(); expect_entry("irq wrap", 4, 16'h0200, 8'h20, 8'h01, 16'hC678);
        run_bnd(); chk("R9 source kept kind", obs_kind, 4);
        pulse(0, 0, 0, 0, '0, 4'b0010, 0);
        chk("R9 line cleared", irq_line, 1'b0);
        run_bnd(); expect_none("R9 cleared source");

        pc_in = 16'h4321; p_in = 8'h00; sp_in = 8'h80;
        pulse(0, 1, 0, 0, '0, '0, 0);
        run_bnd(); expect_promote("late");
        run_bnd(); expect_entry("R3 promoted nmi", 3, 16'h4321, 8'h00, 8'h80, 16'h9011);

        pulse(0, 0, 0, 1, '0, '0, 0);
        chk("R10 shot drives line", irq_line, 1'b1);
        i_prev = 1'b1;
        run_bnd(); expect_none("R10 shot gated");
        chk("R10 shot cleared line", irq_line, 1'b0);
        i_prev = 1'b0;
        run_bnd(); expect_none("R10 shot gone");

        pulse(0, 0, 0, 0, '0, '0, 1);
        chk("R11 jammed set", jammed, 1'b1);
        pulse(0, 0, 1, 0, 4'b0001, '0, 0);
        run_bnd(); expect_none("R11 jammed nmi");
        pulse(0, 0, 0, 0, '0, '0, 0);
        run_bnd(); expect_none("R11 jammed again");
        chk("R11 still jammed", jammed, 1'b1);
        pulse(1, 0, 0, 0, '0, '0, 0);
        run_bnd(); expect_reset("R11 unjam");
        chk("R11 jam cleared", jammed, 1'b0);
        pc_in = 16'h1111; p_in = 8'h04; sp_in = 8'hF0;
        run_bnd(); expect_entry("R11 nmi kept", 3, 16'h1111, 8'h04, 8'hF0, 16'h9011);
        pulse(0, 0, 0, 0, '0, 4'b0001, 0);
        drain();

        for (int c = 0; c < 16; c++) begin
            int ek;
            ek = (c & 8) ? 1 : (c & 4) ? 2 : (c & 2) ? 3 : (c & 1) ? 4 : 0;
            pc_in = 16'(16'h3000 + c); p_in = 8'(c * 17); sp_in = 8'hC0;
            pulse(c[3], c[2], c[1], 0, {3'b000, c[0]}, '0, 0);
            run_bnd();
            chk($sformatf("R1 priority combo %0d", c), obs_kind, ek);
            pulse(0, 0, 0, 0, '0, 4'b0001, 0);
            drain();
        end

        for (int s = 0; s < N; s++) begin
            logic [N-1:0] m;
            m = '0; m[s] = 1'b1;
            pulse(0, 0, 0, 0, m, '0, 0);
            chk($sformatf("R9 source %0d line", s), irq_line, 1'b1);
            pc_in = 16'(16'h5000 + s); p_in = 8'h10; sp_in = 8'h40;
            run_bnd();
            expect_entry($sformatf("R9 source %0d", s), 4, 16'(16'h5000 + s), 8'h10, 8'h40, 16'hC678);
            pulse(0, 0, 0, 0, '0, m, 0);
            chk($sformatf("R9 source %0d cleared", s), irq_line, 1'b0);
        end

        summary();
    end
endmodule